// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between five already-synchronised interrupt flags and a CPU core. The five sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the combined serial receive/transmit event. Software sets up two byte-wide registers over a small register bus. The enable register holds one bit per source and a master switch. The priority register puts each source in the high or the low class. From these settings the controller picks at most one source at a time and offers it to the CPU as a request, together with the source number and an entry address. The request is held until the CPU acknowledges it.

The controller remembers which classes are being serviced in two flags, one for the low class and one for the high class. A grant sets the flag of its class. A return pulse from the CPU clears the high flag if it is set, and clears the low flag otherwise. While the high flag is set nothing is granted. While only the low flag is set, only high-class sources can be granted, which lets a high handler preempt a low one. Among several candidates of the same class, the lowest-numbered source wins. The numbering is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4.

A two-state machine drives the CPU side. `ST_IDLE` takes the transition *grant* to `ST_OFFER` when an eligible source exists that the in-service flags allow. That transition registers the source number and the entry address. `ST_OFFER` keeps the request asserted and takes the transition *acknowledge* back to `ST_IDLE` on the CPU's acknowledge pulse. Every other condition is a *hold* in the current state.

Top module: `vic2_ctrl`

## Requirements
- R1: After reset both registers read 0x00, both in-service flags are clear and `cpu_req` is low.
- R2: With `reg_sel`=0 the bus addresses the enable register and with `reg_sel`=1 the priority register. A write when `reg_wr`=1 takes effect at the clock edge. Enable bits 6 and 5 and priority bits 7..5 always read 0.
- R3: When enable bit 7 (master) is 0, no request is granted whatever the other bits hold.
- R4: With the master bit at 1, source i (src_req bit i) is eligible only if enable bit i is 1. The mapping is bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R5: Priority bit i set to 1 puts source i in the high class. When both classes have eligible sources in the same cycle, a high one is granted.
- R6: Within one class, the lowest source number wins.
- R7: At a grant, `cpu_src` takes the source number and `cpu_vec` takes 0x0003 + 8 × number. Both are visible with `cpu_req` one clock after the edge that sees the eligible source.
- R8: `cpu_req`, `cpu_src` and `cpu_vec` stay unchanged until a cycle with `cpu_ack`=1. `cpu_req` is low after that edge.
- R9: While the low flag is set and the high flag is clear, low-class sources are not granted but high-class sources are.
- R10: While the high flag is set, nothing is granted.
- R11: A `cpu_reti` pulse clears the high flag if it is set, otherwise the low flag. A grant sets the flag of its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 5 | Synchronised request flags, bit i = source i |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects enable register, 1 selects priority register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_req | output | 1 | Interrupt offered to the CPU |
| cpu_src | output | 3 | Number of the granted source |
| cpu_vec | output | 16 | Entry address of the granted source |
| cpu_ack | input | 1 | CPU acknowledge pulse, ends the offer |
| cpu_reti | input | 1 | CPU return-from-handler pulse |

## Verification
Most faults in this block are hidden state, and they show at the ports only when a later request arrives. A stuck or wrongly cleared in-service flag shows up one cycle after a blocked or an allowed source is raised: `cpu_req` rises where it should stay low, or stays low where a grant was due. The bench therefore raises competing sources while handlers are open and watches for the exact grant order across return pulses. A wrong polling order or class decision shows up in the first offered `cpu_src`. A state machine that leaves `ST_OFFER` early shows up as an offer that drops or changes before the acknowledge.

// File: rtl/vic2_pkg.sv
`timescale 1ns/1ps
package vic2_pkg;

    localparam int REG_W   = 8;
    localparam int GLB_BIT = 7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } vic2_state_e;

    function automatic logic [REG_W-1:0] src_mask(input int n_src);
        return REG_W'((1 << n_src) - 1);
    endfunction

    function automatic logic [REG_W-1:0] en_mask(input int n_src);
        return src_mask(n_src) | REG_W'(1 << GLB_BIT);
    endfunction

endpackage

// File: rtl/vic2_regs.sv
`timescale 1ns/1ps
module vic2_regs
    import vic2_pkg::*;
#(
    parameter int N_SRC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              en_glb,
    output logic [N_SRC-1:0]  en_src,
    output logic [N_SRC-1:0]  pri_src
);
    localparam logic [REG_W-1:0] EN_MASK = en_mask(N_SRC);
    localparam logic [REG_W-1:0] PR_MASK = src_mask(N_SRC);

    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] pri_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) pri_q <= wr_data & PR_MASK;
            else        en_q  <= wr_data & EN_MASK;
        end
    end

    assign rd_data = wr_sel ? pri_q : en_q;
    assign en_glb  = en_q[GLB_BIT];
    assign en_src  = en_q[N_SRC-1:0];
    assign pri_src = pri_q[N_SRC-1:0];

endmodule

// File: rtl/vic2_pick.sv
`timescale 1ns/1ps
module vic2_pick #(
    parameter int N_SRC = 5,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0] act,
    input  logic [N_SRC-1:0] pri,
    output logic             hi_any,
    output logic             lo_any,
    output logic [IDX_W-1:0] hi_idx,
    output logic [IDX_W-1:0] lo_idx
);
    logic [N_SRC-1:0] hi_vec;
    logic [N_SRC-1:0] lo_vec;

    assign hi_vec = act & pri;
    assign lo_vec = act & ~pri;
    assign hi_any = |hi_vec;
    assign lo_any = |lo_vec;

    // Scan downward so the lowest-numbered candidate is written last.
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hi_vec[i]) hi_idx = IDX_W'(i);
            if (lo_vec[i]) lo_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/vic2_svc.sv
`timescale 1ns/1ps
module vic2_svc (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic grant_hi,
    input  logic reti,
    output logic in_hi,
    output logic in_lo
);
    logic hi_n;
    logic lo_n;

    always_comb begin
        hi_n = in_hi;
        lo_n = in_lo;
        if (reti) begin
            if (in_hi) hi_n = 1'b0;
            else       lo_n = 1'b0;
        end
        if (grant) begin
            if (grant_hi) hi_n = 1'b1;
            else          lo_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_hi <= 1'b0;
            in_lo <= 1'b0;
        end else begin
            in_hi <= hi_n;
            in_lo <= lo_n;
        end
    end

endmodule

// File: rtl/vic2_ctrl.sv
`timescale 1ns/1ps
module vic2_ctrl
    import vic2_pkg::*;
#(
    parameter int N_SRC         = 5,
    parameter int VEC_W         = 16,
    parameter int VEC_BASE      = 3,
    parameter int VEC_STEP_LOG2 = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          src_req,
    input  logic                      reg_wr,
    input  logic                      reg_sel,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    output logic                      cpu_req,
    output logic [$clog2(N_SRC)-1:0]  cpu_src,
    output logic [VEC_W-1:0]          cpu_vec,
    input  logic                      cpu_ack,
    input  logic                      cpu_reti
);
    localparam int IDX_W = $clog2(N_SRC);

    logic              en_glb;
    logic [N_SRC-1:0]  en_src;
    logic [N_SRC-1:0]  pri_src;
    logic [N_SRC-1:0]  active;
    logic              hi_any, lo_any;
    logic [IDX_W-1:0]  hi_idx, lo_idx;
    logic [IDX_W-1:0]  win_idx;
    logic              grant_ok;
    logic              in_hi, in_lo;
    vic2_state_e       state_q, state_n;
    logic [IDX_W-1:0]  src_q;
    logic [VEC_W-1:0]  vec_q;

    vic2_regs #(.N_SRC(N_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .en_glb  (en_glb),
        .en_src  (en_src),
        .pri_src (pri_src)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign active[g] = src_req[g] & en_src[g] & en_glb;
    end

    vic2_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .act    (active),
        .pri    (pri_src),
        .hi_any (hi_any),
        .lo_any (lo_any),
        .hi_idx (hi_idx),
        .lo_idx (lo_idx)
    );

    assign win_idx  = hi_any ? hi_idx : lo_idx;
    assign grant_ok = (state_q == ST_IDLE) && !in_hi &&
                      (hi_any || (lo_any && !in_lo));

    vic2_svc u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant_ok),
        .grant_hi (hi_any),
        .reti     (cpu_reti),
        .in_hi    (in_hi),
        .in_lo    (in_lo)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // transitions: grant, acknowledge, hold
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (grant_ok) state_n = ST_OFFER;
            ST_OFFER: if (cpu_ack)  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // outputs latched on the grant transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            vec_q <= '0;
        end else if (grant_ok) begin
            src_q <= win_idx;
            vec_q <= VEC_W'(VEC_BASE) + (VEC_W'(win_idx) << VEC_STEP_LOG2);
        end
    end

    assign cpu_req = (state_q == ST_OFFER);
    assign cpu_src = src_q;
    assign cpu_vec = vec_q;

endmodule

// File: rtl/vic2_ctrl_chk.sv
`timescale 1ns/1ps
module vic2_ctrl_chk #(
    parameter int N_SRC         = 5,
    parameter int VEC_W         = 16,
    parameter int VEC_BASE      = 3,
    parameter int VEC_STEP_LOG2 = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_SRC-1:0]         src_req,
    input logic                     reg_sel,
    input logic [7:0]               reg_rdata,
    input logic                     cpu_req,
    input logic [$clog2(N_SRC)-1:0] cpu_src,
    input logic [VEC_W-1:0]         cpu_vec,
    input logic                     cpu_ack,
    input logic                     cpu_reti,
    input logic                     en_glb,
    input logic [N_SRC-1:0]         en_src,
    input logic [N_SRC-1:0]         pri_src,
    input logic                     in_hi,
    input logic                     in_lo
);
    localparam logic [7:0] EN_KEEP = vic2_pkg::en_mask(N_SRC);
    localparam logic [7:0] PR_KEEP = vic2_pkg::src_mask(N_SRC);

    logic hi_pend;
    logic src_is_hi;
    assign hi_pend   = en_glb && |(src_req & en_src & pri_src);
    assign src_is_hi = ((pri_src >> cpu_src) & N_SRC'(1)) != '0;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~(reg_sel ? PR_KEEP : EN_KEEP)) == 8'h00); // R2
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req && !en_glb |=> !cpu_req); // R3
    AST_SRC_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_req) |-> (($past(en_src & src_req) >> cpu_src) & N_SRC'(1)) != '0); // R4
    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_req) && ((($past(pri_src) >> cpu_src) & N_SRC'(1)) == '0) |-> !$past(hi_pend)); // R5
    AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> cpu_vec == VEC_W'(VEC_BASE) + (VEC_W'(cpu_src) << VEC_STEP_LOG2)); // R7
    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_ack |=> cpu_req && $stable(cpu_src) && $stable(cpu_vec)); // R8
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_ack |=> !cpu_req); // R8
    AST_LOW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_req) && !src_is_hi |-> !$past(in_lo)); // R9
    AST_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_hi && !cpu_req |=> !cpu_req); // R10
    AST_RETI_HI: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reti && in_hi |=> !in_hi && (in_lo == $past(in_lo))); // R11
    AST_RETI_LO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reti && !in_hi && in_lo |=> !in_lo); // R11

endmodule

bind vic2_ctrl vic2_ctrl_chk #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP_LOG2(VEC_STEP_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .cpu_req   (cpu_req),
    .cpu_src   (cpu_src),
    .cpu_vec   (cpu_vec),
    .cpu_ack   (cpu_ack),
    .cpu_reti  (cpu_reti),
    .en_glb    (en_glb),
    .en_src    (en_src),
    .pri_src   (pri_src),
    .in_hi     (in_hi),
    .in_lo     (in_lo)
);

// File: tb/test_vic2_ctrl.sv
`timescale 1ns/1ps
module test_vic2_ctrl;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cpu_req;
    logic [2:0] cpu_src;
    logic [15:0] cpu_vec;
    logic       cpu_ack = 1'b0;
    logic       cpu_reti = 1'b0;

    always #10 clk = ~clk;

    vic2_ctrl i_vic2_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_req(cpu_req), .cpu_src(cpu_src), .cpu_vec(cpu_vec),
        .cpu_ack(cpu_ack), .cpu_reti(cpu_reti)
    );

    int    checks = 0;
    int    errors = 0;
    int    ack_delay = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each offer with the scoreboard, then acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (cpu_req) begin
                int    idx;
                string tag;
                if (exp_q.size() == 0) begin
                    idx = -1;
                    tag = "R3/R9/R10 unexpected grant";
                    chk(1'b0, tag, int'(cpu_src), idx);
                end else begin
                    idx = exp_q.pop_front();
                    tag = tag_q.pop_front();
                    chk(int'(cpu_src) == idx, {tag, " R7 source"}, int'(cpu_src), idx);
                    chk(int'(cpu_vec) == 3 + 8 * idx, {tag, " R7 vector"}, int'(cpu_vec), 3 + 8 * idx);
                end
                for (int k = 0; k < ack_delay; k++) begin
                    @(negedge clk);
                    chk(cpu_req && int'(cpu_src) == idx, "R8 offer held", int'(cpu_req), 1);
                end
                cpu_ack = 1'b1;
                @(negedge clk);
                cpu_ack = 1'b0;
                chk(!cpu_req, "R8 drop after ack", int'(cpu_req), 0);
            end
        end
    end

    task automatic expect_src(input int idx, input string tag);
        exp_q.push_back(idx);
        tag_q.push_back(tag);
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !cpu_req && !cpu_ack) break;
        end
        chk(exp_q.size() == 0, {tag, " grant missing"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic quiet(input int n, input string tag);
        bit ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cpu_req) ok = 1'b0;
        end
        chk(ok, tag, int'(!ok), 0);
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_sel = sel;
        #1;
        chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
    endtask

    task automatic reti();
        @(negedge clk); cpu_reti = 1'b1;
        @(negedge clk); cpu_reti = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!cpu_req, "R1 req in reset", int'(cpu_req), 0);
        rst_n = 1'b1;
        rd(1'b0, 8'h00, "R1 enable reset");
        rd(1'b1, 8'h00, "R1 priority reset");
        quiet(3, "R1 idle after reset");

        // R2 register access, reserved bits
        wr(1'b0, 8'hFF);
        rd(1'b0, 8'h9F, "R2 enable readback");
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'h1F, "R2 priority readback");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R2 priority cleared");

        // R3 master switch off blocks everything
        wr(1'b0, 8'h1F);
        src_req = 5'b11111;
        quiet(8, "R3 master off");
        expect_src(0, "R3 master on");
        wr(1'b0, 8'h9F);
        drain("R3");
        src_req = '0;
        reti();

        // R4 per-source enable, timer1 only
        wr(1'b0, 8'h88);
        src_req = 5'b10111;
        quiet(6, "R4 disabled sources");
        expect_src(3, "R4 enabled source");
        src_req = 5'b11111;
        drain("R4");
        src_req = '0;
        reti();

        // R6 low-class polling order across returns
        wr(1'b0, 8'h9F);
        src_req = 5'b11110;
        for (int s = 1; s < N; s++) begin
            expect_src(s, "R6 low order");
            if (s > 1) reti();
            drain("R6");
            src_req[s] = 1'b0;
        end
        reti();

        // R6 high-class polling order
        wr(1'b1, 8'h1F);
        expect_src(3, "R6 high order");
        src_req = 5'b11000;
        drain("R6 high");
        src_req = '0;
        reti();

        // R5 high beats low, R10 high in service blocks, R11 return order
        wr(1'b1, 8'h04);
        expect_src(2, "R5 high wins");
        src_req = 5'b00101;
        drain("R5");
        src_req = 5'b00001;
        quiet(5, "R10 high in service");
        expect_src(0, "R11 high flag cleared");
        reti();
        drain("R11");
        src_req = '0;
        reti();

        // R9 nesting: low running, low blocked, high preempts
        expect_src(0, "R9 first low");
        src_req = 5'b00001;
        drain("R9 first");
        src_req = 5'b00010;
        quiet(5, "R9 low blocked");
        expect_src(2, "R9 high preempts");
        src_req = 5'b00110;
        drain("R9 preempt");
        src_req = 5'b00010;
        quiet(4, "R10 nested high");
        reti();
        quiet(5, "R11 low still in service");
        expect_src(1, "R11 low released");
        reti();
        drain("R11 low");
        src_req = '0;
        reti();

        // R8 offer held until a late acknowledge
        wr(1'b1, 8'h00);
        ack_delay = 4;
        expect_src(4, "R8 serial held");
        src_req = 5'b10000;
        drain("R8");
        ack_delay = 0;
        src_req = '0;
        reti();
        quiet(4, "R11 all returned");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule